// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block generates the address-latch strobe (ALE), the active-low program-read strobe (PSEN) and the high-order address byte for an 8-bit microcontroller whose external memory bus multiplexes the low address byte with data. It runs on the oscillator clock and divides every machine cycle into six states. In standard speed each state lasts two clocks, so a machine cycle is 12 clocks. In double speed each state lasts one clock, so a machine cycle is 6 clocks.

At the end of each machine cycle, the sequencer captures the kind of bus activity for the next cycle from the core: an internal code fetch, an external code fetch, an external data access through a 16-bit pointer, or an external data access through an 8-bit pointer. At the same point it captures the speed select, the ALE-suppress control, the address and the port-2 register value. During the following machine cycle it plays back a fixed strobe pattern for that kind of cycle. The pattern drops pulses during data accesses and can silence ALE during internal fetches. The high-address port holds one value for the whole machine cycle.

Top module: `bus_strobe_seq`

## Requirements
- R1: A synchronous active-high reset `rst` starts the sequencer at slot 0 of a standard-speed machine cycle. While `rst` is high, and for the 12 clocks of the first machine cycle after it is released, `ale` = 0, `psen_n` = 1 and `port_hi` = 8'hFF.
- R2: Inputs are sampled on the last clock of each machine cycle and take effect in the next one. A machine cycle lasts 12 clocks when the sampled `x2_mode` is 0 and 6 clocks when it is 1. States 0 to 5 each last 2 clocks or 1 clock in turn.
- R3: In an external code fetch cycle (`cyc_type` = 1), `ale` is high during states 0 and 3 and low otherwise. This gives a pulse every 6 clocks in standard speed and every 3 clocks in double speed.
- R4: In an external code fetch cycle, `psen_n` is low during states 1 and 4 and high otherwise.
- R5: In an external data cycle (`cyc_type` = 2 for a 16-bit pointer, 3 for an 8-bit pointer), `ale` is high only during state 0, so the state-3 pulse is omitted. `psen_n` stays high for the whole cycle, so both of its pulses are omitted.
- R6: In an internal code fetch cycle (`cyc_type` = 0), `psen_n` stays high.
- R7: In an internal code fetch cycle, `ale` follows the state-0 and state-3 pattern when the sampled `ale_off` is 0 and stays low when it is 1. `ale_off` has no effect on external cycles.
- R8: `port_hi` equals `addr[15:8]` in cycle types 1 and 2. It equals the sampled `p2_reg` in cycle types 0 and 3.
- R9: Changes to any input in the middle of a machine cycle do not alter `ale`, `psen_n` or `port_hi` before the next machine cycle begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| x2_mode | input | 1 | 1 selects double speed (6-clock machine cycle) |
| ale_off | input | 1 | 1 silences ALE during internal code fetches |
| cyc_type | input | 2 | Next cycle kind: 0 internal fetch, 1 external fetch, 2 data via 16-bit pointer, 3 data via 8-bit pointer |
| addr | input | 16 | Bus address for the next cycle |
| p2_reg | input | 8 | Port-2 register contents |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store read strobe, active low |
| port_hi | output | 8 | High-order address port value |

## Verification
The bench changes inputs on every clock, including mid-cycle. A design that sampled inputs outside the cycle boundary would move `port_hi` or a strobe early. It switches between standard and double speed in consecutive machine cycles, which catches a state counter that wraps at the wrong length or splits states with the wrong divisor. Data cycles check that exactly the state-3 ALE pulse and both PSEN pulses vanish; a design that dropped the wrong pulse would shift the address latch for the data phase. Internal fetches are run with `ale_off` both set and clear, and `ale_off` is also set during external cycles, where a design that applied it there would lose ALE.

// File: rtl/esq_pkg.sv
package esq_pkg;

  localparam int STATES            = 6;
  localparam int CLK_PER_STATE_STD = 2;
  localparam int SLOT_W            = $clog2(STATES * CLK_PER_STATE_STD);
  localparam int STATE_W           = $clog2(STATES);
  localparam int STD_SHIFT         = $clog2(CLK_PER_STATE_STD);

  // States in which the address latch fires, and the read strobe that trails each.
  localparam logic [STATE_W-1:0] LATCH_ST_A = STATE_W'(0);
  localparam logic [STATE_W-1:0] LATCH_ST_B = STATE_W'(3);
  localparam logic [STATE_W-1:0] READ_ST_A  = STATE_W'(1);
  localparam logic [STATE_W-1:0] READ_ST_B  = STATE_W'(4);

  typedef enum logic [1:0] {
    CY_INT     = 2'd0,
    CY_XCODE   = 2'd1,
    CY_XDATA_W = 2'd2,
    CY_XDATA_B = 2'd3
  } cyc_e;

  function automatic logic [SLOT_W-1:0] last_slot(input logic x2);
    int n;
    n = x2 ? STATES : STATES * CLK_PER_STATE_STD;
    return SLOT_W'(n - 1);
  endfunction

  function automatic logic [STATE_W-1:0] slot_to_state(input logic [SLOT_W-1:0] s,
                                                       input logic x2);
    logic [SLOT_W-1:0] q;
    q = x2 ? s : (s >> STD_SHIFT);
    return q[STATE_W-1:0];
  endfunction

  function automatic logic is_ext_data(input cyc_e t);
    return (t == CY_XDATA_W) || (t == CY_XDATA_B);
  endfunction

  function automatic logic ale_on(input logic [STATE_W-1:0] st, input cyc_e t,
                                  input logic off);
    logic latch_st;
    latch_st = (st == LATCH_ST_A) || (st == LATCH_ST_B);
    case (t)
      CY_INT:   return latch_st && !off;
      CY_XCODE: return latch_st;
      default:  return st == LATCH_ST_A;
    endcase
  endfunction

  function automatic logic psen_on(input logic [STATE_W-1:0] st, input cyc_e t);
    return (t == CY_XCODE) && ((st == READ_ST_A) || (st == READ_ST_B));
  endfunction

  function automatic logic uses_addr_hi(input cyc_e t);
    return (t == CY_XCODE) || (t == CY_XDATA_W);
  endfunction

endpackage

// File: rtl/esq_timebase.sv
module esq_timebase
  import esq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               x2_q,
  output logic [SLOT_W-1:0]  slot,
  output logic [STATE_W-1:0] state,
  output logic               wrap
);

  assign wrap  = (slot == last_slot(x2_q));
  assign state = slot_to_state(slot, x2_q);

  always_ff @(posedge clk) begin
    if (rst)       slot <= '0;
    else if (wrap) slot <= '0;
    else           slot <= slot + 1'b1;
  end

endmodule

// File: rtl/esq_cycle_latch.sv
module esq_cycle_latch
  import esq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HI_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap,
  input  logic              x2_mode,
  input  logic              ale_off,
  input  logic [1:0]        cyc_type,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HI_W-1:0]   p2_reg,
  output logic              valid_q,
  output logic              x2_q,
  output logic              ale_off_q,
  output cyc_e              type_q,
  output logic [HI_W-1:0]   addr_hi_q,
  output logic [HI_W-1:0]   p2_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      x2_q      <= 1'b0;
      ale_off_q <= 1'b0;
      type_q    <= CY_INT;
      addr_hi_q <= '1;
      p2_q      <= '1;
    end else if (wrap) begin
      valid_q   <= 1'b1;
      x2_q      <= x2_mode;
      ale_off_q <= ale_off;
      type_q    <= cyc_e'(cyc_type);
      addr_hi_q <= addr[ADDR_W-1 -: HI_W];
      p2_q      <= p2_reg;
    end
  end

endmodule

// File: rtl/esq_strobe_decode.sv
module esq_strobe_decode
  import esq_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic               valid_q,
  input  logic [STATE_W-1:0] state,
  input  cyc_e               type_q,
  input  logic               ale_off_q,
  input  logic [HI_W-1:0]    addr_hi_q,
  input  logic [HI_W-1:0]    p2_q,
  output logic               ale,
  output logic               psen_n,
  output logic [HI_W-1:0]    port_hi
);

  always_comb begin
    ale     = valid_q && ale_on(state, type_q, ale_off_q);
    psen_n  = !(valid_q && psen_on(state, type_q));
    port_hi = (valid_q && uses_addr_hi(type_q)) ? addr_hi_q : p2_q;
  end

endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import esq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HI_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              x2_mode,
  input  logic              ale_off,
  input  logic [1:0]        cyc_type,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HI_W-1:0]   p2_reg,
  output logic              ale,
  output logic              psen_n,
  output logic [HI_W-1:0]   port_hi
);

  logic [SLOT_W-1:0]  slot;
  logic [STATE_W-1:0] state;
  logic               wrap;
  logic               valid_q;
  logic               x2_q;
  logic               ale_off_q;
  cyc_e               type_q;
  logic [HI_W-1:0]    addr_hi_q;
  logic [HI_W-1:0]    p2_q;

  esq_timebase u_tb (
    .clk   (clk),
    .rst   (rst),
    .x2_q  (x2_q),
    .slot  (slot),
    .state (state),
    .wrap  (wrap)
  );

  esq_cycle_latch #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap),
    .x2_mode   (x2_mode),
    .ale_off   (ale_off),
    .cyc_type  (cyc_type),
    .addr      (addr),
    .p2_reg    (p2_reg),
    .valid_q   (valid_q),
    .x2_q      (x2_q),
    .ale_off_q (ale_off_q),
    .type_q    (type_q),
    .addr_hi_q (addr_hi_q),
    .p2_q      (p2_q)
  );

  esq_strobe_decode #(.HI_W(HI_W)) u_dec (
    .valid_q   (valid_q),
    .state     (state),
    .type_q    (type_q),
    .ale_off_q (ale_off_q),
    .addr_hi_q (addr_hi_q),
    .p2_q      (p2_q),
    .ale       (ale),
    .psen_n    (psen_n),
    .port_hi   (port_hi)
  );

endmodule

// File: rtl/bus_strobe_seq_chk.sv
module bus_strobe_seq_chk
  import esq_pkg::*;
#(
  parameter int HI_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ale,
  input logic               psen_n,
  input logic [HI_W-1:0]    port_hi,
  input logic [SLOT_W-1:0]  slot,
  input logic [STATE_W-1:0] state,
  input logic               wrap,
  input logic               x2_q,
  input cyc_e               type_q,
  input logic               ale_off_q
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!ale && psen_n && port_hi == '1));

  a_r2_slot_bound: assert property (@(posedge clk) disable iff (rst)
    slot <= last_slot(x2_q));

  a_r2_state_bound: assert property (@(posedge clk) disable iff (rst)
    int'(state) < STATES);

  a_r3_ale_in_latch_states: assert property (@(posedge clk) disable iff (rst)
    ale |-> (state == LATCH_ST_A || state == LATCH_ST_B));

  a_r4_psen_only_ext_code: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (type_q == CY_XCODE));

  a_r5_data_no_psen: assert property (@(posedge clk) disable iff (rst)
    is_ext_data(type_q) |-> psen_n);

  a_r5_data_drops_second_ale: assert property (@(posedge clk) disable iff (rst)
    (is_ext_data(type_q) && state == LATCH_ST_B) |-> !ale);

  a_r6_int_no_psen: assert property (@(posedge clk) disable iff (rst)
    (type_q == CY_INT) |-> psen_n);

  a_r7_ale_suppressed: assert property (@(posedge clk) disable iff (rst)
    (type_q == CY_INT && ale_off_q) |-> !ale);

  a_r9_hi_stable_in_cycle: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(port_hi));

endmodule

bind bus_strobe_seq bus_strobe_seq_chk #(.HI_W(HI_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ale       (ale),
  .psen_n    (psen_n),
  .port_hi   (port_hi),
  .slot      (slot),
  .state     (state),
  .wrap      (wrap),
  .x2_q      (x2_q),
  .type_q    (type_q),
  .ale_off_q (ale_off_q)
);

// File: tb/bus_strobe_seq_test.sv
`timescale 1ns/1ps
module bus_strobe_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        x2_mode = 1'b0;
  logic        ale_off = 1'b0;
  logic [1:0]  cyc_type = 2'd0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  p2_reg = 8'h00;
  logic        ale;
  logic        psen_n;
  logic [7:0]  port_hi;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_strobe_seq uut (
    .clk(clk), .rst(rst), .x2_mode(x2_mode), .ale_off(ale_off),
    .cyc_type(cyc_type), .addr(addr), .p2_reg(p2_reg),
    .ale(ale), .psen_n(psen_n), .port_hi(port_hi)
  );

  // Expected pins for one clock plus the requirement each pin stands for.
  typedef struct packed {
    logic       a;
    logic       p;
    logic [7:0] h;
    logic [3:0] ta;
    logic [3:0] tp;
  } exp_t;

  exp_t plan[$];

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Idle machine cycle after reset (R1).
  task automatic plan_idle();
    exp_t e;
    for (int k = 0; k < 12; k++) begin
      e.a = 1'b0; e.p = 1'b1; e.h = 8'hFF; e.ta = 4'd1; e.tp = 4'd1;
      plan.push_back(e);
    end
  endtask

  // Builds one machine cycle from what the bench drives at the boundary.
  task automatic plan_cycle(input bit x2, input int t, input bit off,
                            input logic [15:0] a, input logic [7:0] p2);
    int len;
    int per;
    bit [5:0] ale_states;
    bit [5:0] rd_states;
    exp_t e;
    len = x2 ? 6 : 12;
    per = x2 ? 1 : 2;
    rd_states = 6'b000000;
    case (t)
      0: ale_states = off ? 6'b000000 : 6'b001001;
      1: begin ale_states = 6'b001001; rd_states = 6'b010010; end
      default: ale_states = 6'b000001;
    endcase
    for (int k = 0; k < len; k++) begin
      e.a  = ale_states[k / per];
      e.p  = !rd_states[k / per];
      e.h  = (t == 1 || t == 2) ? a[15:8] : p2;
      e.ta = (t == 0) ? 4'd7 : (t == 1) ? 4'd3 : 4'd5;
      e.tp = (t == 0) ? 4'd6 : (t == 1) ? 4'd4 : 4'd5;
      plan.push_back(e);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      plan.delete();
      plan_idle();
    end else if (plan.size() > 0) begin
      void'(plan.pop_front());
      if (plan.size() == 0)
        plan_cycle(x2_mode, int'(cyc_type), ale_off, addr, p2_reg);
    end
  end

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!done && plan.size() > 0) begin
      exp_t e;
      e = plan[0];
      chk(ale == e.a, int'(e.ta), "ale", int'(ale), int'(e.a));
      chk(psen_n == e.p, int'(e.tp), "psen_n", int'(psen_n), int'(e.p));
      // R8 R9: port value and its stability inside a cycle
      chk(port_hi == e.h, 8, "port_hi", int'(port_hi), int'(e.h));
    end
  end

  // R2: spacing between ALE rises in external code fetch.
  task automatic ale_spacing(input bit x2);
    bit pv;
    int c;
    pv = ale;
    for (int g = 0; g < 40; g++) begin
      @(negedge clk);
      if (ale && !pv) break;
      pv = ale;
    end
    c = 0;
    pv = 1'b1;
    for (int g = 0; g < 40; g++) begin
      @(negedge clk);
      c++;
      if (ale && !pv) break;
      pv = ale;
    end
    chk(c == (x2 ? 3 : 6), 2, "ale period", c, x2 ? 3 : 6);
  endtask

  task automatic check_idle_now();
    // R1: idle pins straight after reset
    chk(ale == 1'b0, 1, "ale after reset", int'(ale), 0);
    chk(psen_n == 1'b1, 1, "psen_n after reset", int'(psen_n), 1);
    chk(port_hi == 8'hFF, 1, "port_hi after reset", int'(port_hi), 255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle_now();

    for (int x = 0; x < 2; x++) begin
      for (int t = 0; t < 4; t++) begin
        for (int o = 0; o < 2; o++) begin
          x2_mode  = x[0];
          cyc_type = t[1:0];
          ale_off  = o[0];
          p2_reg   = 8'($urandom);
          for (int k = 0; k < 30; k++) begin
            // R9: address moves mid-cycle
            if (k % 5 == 0) addr = 16'($urandom);
            @(negedge clk);
          end
          if (t == 1) ale_spacing(x[0]);
        end
      end
    end

    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle_now();

    for (int k = 0; k < 3000; k++) begin
      x2_mode  = 1'($urandom);
      ale_off  = 1'($urandom);
      cyc_type = 2'($urandom);
      addr     = 16'($urandom);
      p2_reg   = 8'($urandom);
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule